// File: doc/BRIEF.md
# Two-Level Eight-Source Interrupt Controller

This block arbitrates interrupt requests from eight sources for an 8-bit controller core. Four sources are external, active-low pins. Each pin can be sampled as a low level or as a falling edge. The other four are request lines that the core's peripherals already hold: timer 0, timer 1, the serial port and timer 2. Every source has an enable bit and a priority bit that choose one of two levels. A global enable gates all of them. The block picks one winner, raises a request to the CPU and presents a fixed 16-bit vector address for it.

The CPU takes the request with a one-cycle acknowledge. On that cycle the block marks the winner's level as in service. It also pulses a one-hot strobe naming the flag to clear when that flag is hardware-cleared. A low-level handler can be interrupted by a high-level request. A high-level handler cannot be interrupted at all. A return pulse ends the innermost handler.

The two extra external sources take their controls from a single 8-bit control byte. The other two external pins take their trigger-mode bits from a small separate input. The pins are sampled only on machine-cycle ticks.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The vector is 0x0003 + 8 × index, where the source index order is INT0=0, TMR0=1, INT1=2, TMR1=3, UART=4, TMR2=5, INT2=6, INT3=7. This gives 0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B, 0x33 and 0x3B.
- R2: Any pending high-level source wins over every pending low-level source. Within a level, the lowest index wins.
- R3: The control byte `ext_ctl` holds, from bit 7 down to bit 0: INT3 priority, INT3 enable, (ignored), INT3 edge mode, INT2 priority, INT2 enable, (ignored), INT2 edge mode. Bits 5 and 1 have no effect on any output.
- R4: In edge mode, the flag of an external source is set on a tick where the previous ticked sample of the pin was 1 and the current pin is 0. A pin that stays low sets nothing new, and a pin change between ticks is not seen. The flag shows on `ext_flags` after that clock edge.
- R5: When an edge-mode external source is acknowledged, its `flag_clr` bit pulses in the acknowledge cycle and its flag reads 0 on the next cycle.
- R6: In level mode, an external flag takes the inverse of the pin on each tick. Acknowledge neither clears it nor pulses its `flag_clr` bit.
- R7: A source whose enable bit is 0, or any source while `glb_en` is 0, raises no request. Its flag is still recorded.
- R8: While a low-level handler is in service, only high-level sources can request. While a high-level handler is in service, nothing requests.
- R9: `reti` ends the high-level handler if one is in service, otherwise the low-level one.
- R10: `cpu_ack` while `irq_req` is 0 changes no state.
- R11: `flag_clr` is 0 outside a granted acknowledge. In a granted acknowledge it is one-hot on the served index for TMR0, TMR1 and edge-mode external sources, and 0 for UART, TMR2 and level-mode external sources.
- R12: After reset, `irq_req`, `ext_flags` and `flag_clr` are 0 and no handler is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle tick; external pins are sampled on it |
| ext_pin_n | input | 4 | External pins INT3..INT0, active low |
| ext_it01 | input | 2 | Edge-mode bits for INT1, INT0 |
| ext_ctl | input | 8 | Control byte for INT2/INT3 (see R3) |
| periph_req | input | 4 | Peripheral requests TMR2, UART, TMR1, TMR0 |
| src_en | input | 6 | Enables for indices 5..0 |
| src_hi | input | 6 | High-level priority bits for indices 5..0 |
| glb_en | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | CPU acknowledge of the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the winner |
| flag_clr | output | 8 | One-hot flag-clear strobe by source index |
| ext_flags | output | 4 | Flags of INT3..INT0 |

## Verification
The bench builds the block with its default parameters: eight sources, four of them external, and a 16-bit vector. At this size, all 256 combinations of pending sources can be swept under four different priority masks, and each result is compared with an arithmetic model of the polling order and the vector formula. Directed sequences then exercise the rest. They cover edge detection only on ticks, clearing on acknowledge, level flags that survive acknowledge, preemption of a low handler by a high one, and the order in which `reti` unwinds two nested levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N = 8;
  localparam int EXT_N = 4;
  localparam int IDX_W = $clog2(SRC_N);

  localparam int SRC_INT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_INT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_UART = 4;
  localparam int SRC_TMR2 = 5;
  localparam int SRC_INT2 = 6;
  localparam int SRC_INT3 = 7;

  typedef enum logic [0:0] {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  // source index of external pin k
  function automatic int ext_src(input int k);
    case (k)
      0: ext_src = SRC_INT0;
      1: ext_src = SRC_INT1;
      2: ext_src = SRC_INT2;
      default: ext_src = SRC_INT3;
    endcase
  endfunction

  // lowest set index of a request vector (0 when empty)
  function automatic logic [IDX_W-1:0] first_one(input logic [SRC_N-1:0] v);
    first_one = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) first_one = IDX_W'(i);
    end
  endfunction
endpackage

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic samp_q, samp_d;
  logic flag_q, flag_d;
  logic fall;

  assign fall = tick & samp_q & ~pin_n;

  always_comb begin
    samp_d = samp_q;
    flag_d = flag_q;
    if (tick) samp_d = pin_n;
    if (edge_mode) begin
      if (fall)      flag_d = 1'b1;
      else if (clr)  flag_d = 1'b0;
    end else if (tick) begin
      flag_d = ~pin_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_pkg::*;
(
  input  logic [SRC_N-1:0] pend,
  input  logic [SRC_N-1:0] hi,
  input  logic             ins_lo,
  input  logic             ins_hi,
  output logic             req,
  output logic [IDX_W-1:0] idx,
  output lvl_e             lvl
);
  logic [SRC_N-1:0] hi_pend, lo_pend;
  logic             hi_ok, lo_ok;

  assign hi_pend = pend & hi;
  assign lo_pend = pend & ~hi;
  assign hi_ok   = !ins_hi && (|hi_pend);
  assign lo_ok   = !ins_hi && !ins_lo && (|lo_pend);

  always_comb begin
    req = 1'b0;
    idx = '0;
    lvl = LVL_LO;
    if (hi_ok) begin
      req = 1'b1;
      idx = first_one(hi_pend);
      lvl = LVL_HI;
    end else if (lo_ok) begin
      req = 1'b1;
      idx = first_one(lo_pend);
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  lvl_e grant_lvl,
  input  logic reti,
  output logic ins_lo,
  output logic ins_hi
);
  logic lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (reti) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (grant) begin
      if (grant_lvl == LVL_HI) hi_d = 1'b1;
      else                     lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign ins_lo = lo_q;
  assign ins_hi = hi_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic [EXT_N-1:0] ext_pin_n,
  input  logic [1:0]       ext_it01,
  input  logic [7:0]       ext_ctl,
  input  logic [3:0]       periph_req,
  input  logic [5:0]       src_en,
  input  logic [5:0]       src_hi,
  input  logic             glb_en,
  input  logic             cpu_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [SRC_N-1:0] flag_clr,
  output logic [EXT_N-1:0] ext_flags
);
  logic [EXT_N-1:0] ext_edge;
  logic [SRC_N-1:0] en8, hi8, flags8, pend8, clearable8;
  logic [IDX_W-1:0] sel_idx;
  lvl_e             sel_lvl;
  logic             grant;
  logic             ins_lo, ins_hi;

  assign ext_edge = {ext_ctl[4], ext_ctl[0], ext_it01[1], ext_it01[0]};
  assign en8      = {ext_ctl[6], ext_ctl[2], src_en};
  assign hi8      = {ext_ctl[7], ext_ctl[3], src_hi};

  assign flags8 = {ext_flags[3], ext_flags[2], periph_req[3], periph_req[2],
                   periph_req[1], ext_flags[1], periph_req[0], ext_flags[0]};
  assign pend8  = flags8 & en8 & {SRC_N{glb_en}};

  assign clearable8 = {ext_edge[3], ext_edge[2], 1'b0, 1'b0,
                       1'b1, ext_edge[1], 1'b1, ext_edge[0]};

  generate
    for (genvar k = 0; k < EXT_N; k++) begin : g_ext
      irq_ext_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mc_tick),
        .pin_n    (ext_pin_n[k]),
        .edge_mode(ext_edge[k]),
        .clr      (flag_clr[ext_src(k)]),
        .flag     (ext_flags[k])
      );
    end
  endgenerate

  irq_poll u_poll (
    .pend  (pend8),
    .hi    (hi8),
    .ins_lo(ins_lo),
    .ins_hi(ins_hi),
    .req   (irq_req),
    .idx   (sel_idx),
    .lvl   (sel_lvl)
  );

  assign grant = cpu_ack & irq_req;

  irq_nest u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .grant_lvl(sel_lvl),
    .reti     (reti),
    .ins_lo   (ins_lo),
    .ins_hi   (ins_hi)
  );

  always_comb begin
    flag_clr = '0;
    if (grant) flag_clr = clearable8 & (SRC_N'(1) << sel_idx);
  end

  assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(sel_idx);
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       cpu_ack,
  input logic       reti,
  input logic       irq_req,
  input logic [2:0] vec_lo,
  input logic [7:0] flag_clr,
  input logic       ins_lo,
  input logic       ins_hi
);
  // R1: every vector sits at 8n+3
  p_vec_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> vec_lo == 3'b011);

  // R7: global disable silences all requests
  p_glb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);

  // R8: a high handler blocks everything
  p_hi_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_req);

  // R8: a granted acknowledge leaves a handler in service
  p_ack_enters_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req) |=> (ins_lo || ins_hi));

  // R9: return ends an in-service high handler
  p_reti_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_hi && !cpu_ack) |=> !ins_hi);

  // R11: strobe at most one-hot
  p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));

  // R11: strobe only in a granted acknowledge
  p_clr_on_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> (cpu_ack && irq_req));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .glb_en  (glb_en),
  .cpu_ack (cpu_ack),
  .reti    (reti),
  .irq_req (irq_req),
  .vec_lo  (irq_vec[2:0]),
  .flag_clr(flag_clr),
  .ins_lo  (ins_lo),
  .ins_hi  (ins_hi)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mc_tick;
  logic [3:0]  ext_pin_n;
  logic [1:0]  ext_it01;
  logic [7:0]  ext_ctl;
  logic [3:0]  periph_req;
  logic [5:0]  src_en;
  logic [5:0]  src_hi;
  logic        glb_en;
  logic        cpu_ack;
  logic        reti;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [7:0]  flag_clr;
  logic [3:0]  ext_flags;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] clr_seen;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_pin_n(ext_pin_n),
    .ext_it01(ext_it01), .ext_ctl(ext_ctl), .periph_req(periph_req),
    .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .cpu_ack(cpu_ack),
    .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr),
    .ext_flags(ext_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mc_tick = 1'b0; ext_pin_n = 4'hF; ext_it01 = 2'b00;
    ext_ctl = 8'h44; periph_req = 4'h0; src_en = 6'h3F; src_hi = 6'h00;
    glb_en = 1'b1; cpu_ack = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0;
  endtask

  task automatic ack_once();
    @(negedge clk); cpu_ack = 1'b1;
    #1 clr_seen = flag_clr;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic reti_once();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  // drive a pending pattern by source index; external pins in level mode
  task automatic drive_pend(input logic [7:0] m);
    ext_pin_n  = ~{m[7], m[6], m[2], m[0]};
    periph_req = {m[5], m[4], m[3], m[1]};
  endtask

  function automatic int exp_idx(input logic [7:0] p, input logic [7:0] h);
    logic [7:0] v;
    v = ((p & h) != 0) ? (p & h) : p;
    exp_idx = 0;
    for (int i = 7; i >= 0; i--) if (v[i]) exp_idx = i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    check("R12 irq_req", irq_req, 0);
    check("R12 ext_flags", ext_flags, 0);
    check("R12 flag_clr", flag_clr, 0);

    // R1/R2 sweep over all pending patterns and four priority masks
    for (int pm = 0; pm < 4; pm++) begin
      logic [7:0] hp;
      hp = (pm == 0) ? 8'h00 : (pm == 1) ? 8'hFF : (pm == 2) ? 8'hA5 : 8'h3C;
      src_hi  = hp[5:0];
      ext_ctl = {hp[7], 3'b100, hp[6], 3'b100};
      for (int m = 0; m < 256; m++) begin
        @(negedge clk);
        drive_pend(8'(m));
        tick_once();
        check("R2 irq_req", irq_req, (m != 0));
        if (m != 0) check("R1 R2 irq_vec", irq_vec, 3 + 8 * exp_idx(8'(m), hp));
      end
    end

    // R7 disable gating
    do_reset();
    @(negedge clk); drive_pend(8'hFF); glb_en = 1'b0;
    tick_once();
    check("R7 glb_en off", irq_req, 0);
    check("R7 flags kept", ext_flags, 4'hF);
    @(negedge clk); glb_en = 1'b1; src_en = 6'h00; ext_ctl = 8'h00;
    #1 check("R7 all enables off", irq_req, 0);

    // R3 ignored bits and INT2/INT3 controls
    @(negedge clk); drive_pend(8'h40); ext_ctl = 8'h22;
    tick_once();
    check("R3 ignored bits no req", irq_req, 0);
    check("R7 INT2 flag recorded", ext_flags[2], 1);
    @(negedge clk); ext_ctl = 8'h26;
    #1 check("R3 EX2 enables", irq_vec, 16'h33);
    check("R3 req", irq_req, 1);
    @(negedge clk); drive_pend(8'hC0); ext_ctl = 8'hE6;
    tick_once();
    check("R3 PX3 raises INT3", irq_vec, 16'h3B);

    // R10 stray ack, then low request must appear
    do_reset();
    ack_once();
    check("R10 stray ack no strobe", clr_seen, 0);
    @(negedge clk); periph_req = 4'b0001;
    #1 check("R10 request after stray ack", irq_vec, 16'h0B);
    check("R10 req", irq_req, 1);

    // R8/R9/R11 nesting
    do_reset();
    @(negedge clk); periph_req = 4'b0010;
    #1 check("R1 TMR1 vector", irq_vec, 16'h1B);
    ack_once();
    check("R11 TMR1 strobe", clr_seen, 8'h08);
    check("R8 low blocks low", irq_req, 0);
    @(negedge clk); periph_req = 4'b0110; src_hi = 6'h10;
    #1 check("R8 high preempts low", irq_vec, 16'h23);
    check("R8 req", irq_req, 1);
    ack_once();
    check("R11 UART no strobe", clr_seen, 0);
    @(negedge clk); src_hi = 6'h11; ext_pin_n = 4'hE;
    tick_once();
    check("R8 high blocks all", irq_req, 0);
    reti_once();
    check("R9 reti ends high", irq_vec, 16'h03);
    check("R9 req", irq_req, 1);
    @(negedge clk); src_hi = 6'h00;
    #1 check("R8 low still in service", irq_req, 0);
    reti_once();
    check("R9 reti ends low", irq_req, 1);
    check("R9 vector", irq_vec, 16'h03);

    // R4/R5 edge mode on INT1
    do_reset();
    @(negedge clk); ext_it01 = 2'b10;
    tick_once();
    @(negedge clk); ext_pin_n = 4'hD;
    repeat (2) @(negedge clk);
    check("R4 no tick no edge", ext_flags[1], 0);
    tick_once();
    check("R4 edge sets flag", ext_flags[1], 1);
    check("R1 INT1 vector", irq_vec, 16'h13);
    ack_once();
    check("R5 INT1 strobe", clr_seen, 8'h04);
    check("R5 flag cleared", ext_flags[1], 0);
    tick_once();
    check("R4 held low no new edge", ext_flags[1], 0);
    reti_once();
    @(negedge clk); ext_pin_n = 4'hF;
    tick_once();
    @(negedge clk); ext_pin_n = 4'hD;
    tick_once();
    check("R4 second edge", ext_flags[1], 1);

    // R6 level mode on INT0 survives ack
    @(negedge clk); ext_pin_n = 4'hC;
    tick_once();
    check("R6 level flag", ext_flags[0], 1);
    check("R2 INT0 wins", irq_vec, 16'h03);
    ack_once();
    check("R6 no strobe", clr_seen, 0);
    check("R6 flag kept", ext_flags[0], 1);
    check("R5 unserved edge flag kept", ext_flags[1], 1);
    @(negedge clk); ext_pin_n = 4'hD;
    tick_once();
    check("R6 flag follows pin", ext_flags[0], 0);

    summary();
    $finish;
  end
endmodule